// File: doc/BRIEF.md
# Jog-driven factory test menu controller

This block sequences a factory test mode from a small set of user inputs: single-cycle jog events (turn right, turn left, push), a held MENU key level and a SET key press. Once test mode is entered, it presents a circular list of seven test items. Right and left jog turns move through the list. A push launches the shown item through a one-cycle start strobe. Choosing the exit entry leaves test mode.

While an item is running, the controller keeps track of the check step inside that item. A push moves to the next check. The block also offers two confirmation sub-states:

- A right turn asks to skip the current check.
- A left turn asks to abandon the item and go to the next one.

In both sub-states a push confirms, a right turn cancels, and a left turn does nothing. When an item ends, the selection screen comes back showing the item that follows the one just finished. If the selection screen sees no input for longer than a programmable number of ticks, test mode is released.

The test routines themselves, the display driver and the jog decoder are outside this block. A routine may end its item early by pulsing a done input.

Top module: `jog_test_menu`

## Requirements
- R1: After reset, in_test_o=0, item_o=0, check_o=0, blink_o=0 and start_o=0.
- R2: A key_set_i pulse while key_menu_i is high enters test mode. On the next cycle in_test_o=1, item_o=0 and blink_o=1. A key_set_i pulse while key_menu_i is low has no effect.
- R3: The item codes are 0 BATT, 1 LCD, 2 KEY, 3 LEARN, 4 MEMORY, 5 MEMORY ERASE and 6 EXIT. On the selection screen a right turn sets item_o to (item+1) mod 7, and a left turn sets it to (item+6) mod 7.
- R4: A push on the selection screen at items 0..5 makes start_o high for exactly one cycle. That cycle is the one after the push, and in it blink_o=0 and check_o=0. A push at item 6 clears in_test_o.
- R5: While an item runs, a push increments check_o. The item has C checks: 2, 11, 34, 2, 3 and 1 for items 0..5. A push at check C-1 returns to the selection screen (blink_o=1, check_o=0) with item_o=(item+1) mod 7.
- R6: A right turn while running enters skip-confirm (blink_o=1). In that state:
  - A push behaves as the run-state push of R5.
  - A right turn returns to the run state with check_o unchanged.
  - A left turn changes nothing.
- R7: A left turn while running enters next-confirm (blink_o=1). In that state:
  - A push returns to the selection screen with item_o=(item+1) mod 7.
  - A right turn returns to the run state with check_o unchanged.
  - A left turn changes nothing.
- R8: An item_done_i pulse in the run state, with no jog event in the same cycle, returns to the selection screen with item_o=(item+1) mod 7.
- R9: On the selection screen, test mode is released on the (TIMEOUT_TICKS+1)-th consecutive tick_i pulse with no jog event or SET press in between. Any such event restarts the count. Ticks have no effect outside the selection screen.
- R10: When several jog events arrive in one cycle, push wins over right, and right wins over left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jog_right_i | input | 1 | Right turn event, one-cycle pulse |
| jog_left_i | input | 1 | Left turn event, one-cycle pulse |
| jog_push_i | input | 1 | Jog push event, one-cycle pulse |
| key_menu_i | input | 1 | MENU key held level |
| key_set_i | input | 1 | SET key press, one-cycle pulse |
| tick_i | input | 1 | Timeout time base pulse |
| item_done_i | input | 1 | Running item finished, one-cycle pulse |
| item_o | output | 3 | Current item code |
| check_o | output | 6 | Current check step within the running item |
| blink_o | output | 1 | Blinking label enable (selection or confirm screen) |
| in_test_o | output | 1 | Test mode active |
| start_o | output | 1 | One-cycle launch strobe |

## Verification
A corrupted state register shows up on blink_o and check_o in the cycle right after the next jog event. For example, a confirm state mistaken for the run state would let a left turn change blink_o, or a right turn would leave check_o advancing. A wrong ring step or a wrong check count shows up as a wrong item_o at the next selection screen. This is detected within one push of the last check, so the bench walks every item through all its checks and around the full ring in both directions. An off-by-one in the timeout counter moves the in_test_o drop by one tick, so the bench samples on both sides of that boundary.

// File: rtl/jtm_pkg.sv
package jtm_pkg;
  localparam int unsigned N_ITEMS   = 7;
  localparam int unsigned ITEM_W    = $clog2(N_ITEMS);
  localparam int unsigned CHK_W     = 6;
  localparam logic [ITEM_W-1:0] ITEM_EXIT = ITEM_W'(N_ITEMS - 1);

  typedef enum logic [2:0] {ST_OFF, ST_SEL, ST_RUN, ST_SKIP, ST_NEXT} state_e;
  typedef enum logic [1:0] {EV_NONE, EV_PUSH, EV_RIGHT, EV_LEFT} ev_e;

  // number of check steps per item
  function automatic logic [CHK_W-1:0] checks_of(input logic [ITEM_W-1:0] it);
    case (it)
      3'd0:    checks_of = CHK_W'(2);
      3'd1:    checks_of = CHK_W'(11);
      3'd2:    checks_of = CHK_W'(34);
      3'd3:    checks_of = CHK_W'(2);
      3'd4:    checks_of = CHK_W'(3);
      default: checks_of = CHK_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/jtm_event_arb.sv
module jtm_event_arb
  import jtm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic right_i,
  input  logic left_i,
  output ev_e  ev_o,
  output logic any_o
);
  always_comb begin
    if (push_i)       ev_o = EV_PUSH;
    else if (right_i) ev_o = EV_RIGHT;
    else if (left_i)  ev_o = EV_LEFT;
    else              ev_o = EV_NONE;
  end
  assign any_o = push_i | right_i | left_i;

  // R10: a left event never wins over a right event
  a_r10_left_loses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_i |-> ev_o != EV_LEFT);
endmodule

// File: rtl/jtm_ring.sv
module jtm_ring #(
  parameter int unsigned N = 7,
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] idx_i,
  output logic [W-1:0] inc_o,
  output logic [W-1:0] dec_o
);
  assign inc_o = (idx_i == W'(N - 1)) ? '0 : idx_i + 1'b1;
  assign dec_o = (idx_i == '0) ? W'(N - 1) : idx_i - 1'b1;
endmodule

// File: rtl/jtm_idle_timer.sv
module jtm_idle_timer #(
  parameter int unsigned TIMEOUT_TICKS = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1);
  logic [CW-1:0] cnt_q;

  assign expire_o = !clr_i && tick_i && (cnt_q == CW'(TIMEOUT_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (clr_i || expire_o)                cnt_q <= '0;
    else if (tick_i)                           cnt_q <= cnt_q + 1'b1;
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TIMEOUT_TICKS));
  a_r9_clr_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/jog_test_menu.sv
module jog_test_menu
  import jtm_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              jog_right_i,
  input  logic              jog_left_i,
  input  logic              jog_push_i,
  input  logic              key_menu_i,
  input  logic              key_set_i,
  input  logic              tick_i,
  input  logic              item_done_i,
  output logic [ITEM_W-1:0] item_o,
  output logic [CHK_W-1:0]  check_o,
  output logic              blink_o,
  output logic              in_test_o,
  output logic              start_o
);
  state_e              state_q, state_d;
  logic [ITEM_W-1:0]   item_q, item_d, item_inc, item_dec;
  logic [CHK_W-1:0]    chk_q, chk_d;
  logic                start_q, start_d;
  ev_e                 ev;
  logic                any_ev, expire, chk_last, tmr_clr;

  jtm_event_arb i_arb (
    .clk_i, .rst_ni,
    .push_i (jog_push_i), .right_i(jog_right_i), .left_i(jog_left_i),
    .ev_o   (ev), .any_o(any_ev)
  );

  jtm_ring #(.N(N_ITEMS), .W(ITEM_W)) i_ring (
    .idx_i(item_q), .inc_o(item_inc), .dec_o(item_dec)
  );

  assign tmr_clr = (state_q != ST_SEL) || any_ev || key_set_i;

  jtm_idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_timer (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .tick_i, .expire_o(expire)
  );

  assign chk_last = (chk_q + 1'b1) == checks_of(item_q);

  always_comb begin
    state_d = state_q;
    item_d  = item_q;
    chk_d   = chk_q;
    start_d = 1'b0;
    case (state_q)
      ST_OFF: if (key_set_i && key_menu_i) begin
        state_d = ST_SEL;
        item_d  = '0;
        chk_d   = '0;
      end
      ST_SEL: case (ev)
        EV_PUSH: if (item_q == ITEM_EXIT) begin
          state_d = ST_OFF;
          item_d  = '0;
        end else begin
          state_d = ST_RUN;
          chk_d   = '0;
          start_d = 1'b1;
        end
        EV_RIGHT: item_d = item_inc;
        EV_LEFT:  item_d = item_dec;
        default: if (expire) begin
          state_d = ST_OFF;
          item_d  = '0;
        end
      endcase
      ST_RUN, ST_SKIP: case (ev)
        EV_PUSH: if (chk_last) begin
          state_d = ST_SEL;
          item_d  = item_inc;
          chk_d   = '0;
        end else begin
          state_d = ST_RUN;
          chk_d   = chk_q + 1'b1;
        end
        EV_RIGHT: state_d = (state_q == ST_RUN) ? ST_SKIP : ST_RUN;
        EV_LEFT:  if (state_q == ST_RUN) state_d = ST_NEXT;
        default:  if (state_q == ST_RUN && item_done_i) begin
          state_d = ST_SEL;
          item_d  = item_inc;
          chk_d   = '0;
        end
      endcase
      ST_NEXT: case (ev)
        EV_PUSH: begin
          state_d = ST_SEL;
          item_d  = item_inc;
          chk_d   = '0;
        end
        EV_RIGHT: state_d = ST_RUN;
        default: ;
      endcase
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      item_q  <= '0;
      chk_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      item_q  <= item_d;
      chk_q   <= chk_d;
      start_q <= start_d;
    end
  end

  assign item_o    = item_q;
  assign check_o   = chk_q;
  assign start_o   = start_q;
  assign in_test_o = state_q != ST_OFF;
  assign blink_o   = (state_q == ST_SEL) || (state_q == ST_SKIP) || (state_q == ST_NEXT);

  a_r3_item_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_q < ITEM_W'(N_ITEMS));
  a_r3_right_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL && ev == EV_RIGHT) |=>
      item_q == (($past(item_q) == ITEM_EXIT) ? '0 : $past(item_q) + 1'b1));
  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  a_r4_start_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (state_q == ST_RUN && chk_q == '0));
  a_r6_skip_left_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP && ev == EV_LEFT) |=>
      (state_q == ST_SKIP && $stable(chk_q) && $stable(item_q)));
  a_r7_next_left_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NEXT && ev == EV_LEFT) |=>
      (state_q == ST_NEXT && $stable(chk_q) && $stable(item_q)));
  a_r9_timeout_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL && expire) |=> state_q == ST_OFF);
  a_r10_push_launches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL && jog_push_i && item_q != ITEM_EXIT) |=> start_q);
endmodule

// File: tb/test_jog_test_menu.sv
module test_jog_test_menu;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic jr = 0, jl = 0, jp = 0, km = 0, ks = 0, tk = 0, dn = 0;
  logic [2:0] item;
  logic [5:0] chk;
  logic blink, in_test, start;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  jog_test_menu #(.TIMEOUT_TICKS(60)) i_jog_test_menu (
    .clk_i(clk), .rst_ni(rst_ni), .jog_right_i(jr), .jog_left_i(jl),
    .jog_push_i(jp), .key_menu_i(km), .key_set_i(ks), .tick_i(tk),
    .item_done_i(dn), .item_o(item), .check_o(chk), .blink_o(blink),
    .in_test_o(in_test), .start_o(start)
  );

  function automatic int n_checks(input int it);
    case (it)
      0: n_checks = 2;  1: n_checks = 11; 2: n_checks = 34;
      3: n_checks = 2;  4: n_checks = 3;  default: n_checks = 1;
    endcase
  endfunction

  task automatic chk_eq(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic r, input logic l, input logic p,
                       input logic s, input logic d);
    @(negedge clk);
    jr = r; jl = l; jp = p; ks = s; dn = d;
    @(negedge clk);
    jr = 0; jl = 0; jp = 0; ks = 0; dn = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tk = 1;
    repeat (n) @(negedge clk);
    tk = 0;
  endtask

  task automatic enter();
    km = 1;
    drive(0, 0, 0, 1, 0);
    km = 0;
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk_eq("R1", "in_test", in_test, 0);
    chk_eq("R1", "item", item, 0);
    chk_eq("R1", "check", chk, 0);
    chk_eq("R1", "blink", blink, 0);
    chk_eq("R1", "start", start, 0);
    // R2
    drive(0, 0, 0, 1, 0);
    chk_eq("R2", "set without menu", in_test, 0);
    enter();
    chk_eq("R2", "in_test", in_test, 1);
    chk_eq("R2", "item", item, 0);
    chk_eq("R2", "blink", blink, 1);
    // R3 full ring sweeps
    e = 0;
    for (int i = 0; i < 14; i++) begin
      drive(1, 0, 0, 0, 0);
      e = (e + 1) % 7;
      chk_eq("R3", "right step", item, e);
    end
    for (int i = 0; i < 14; i++) begin
      drive(0, 1, 0, 0, 0);
      e = (e + 6) % 7;
      chk_eq("R3", "left step", item, e);
    end
    // R10: right beats left
    drive(1, 1, 0, 0, 0);
    chk_eq("R10", "right over left", item, 1);
    drive(0, 1, 0, 0, 0);
    chk_eq("R3", "back to 0", item, 0);
    // R4/R5 run every item through all checks; R10 push over right+left
    for (int it = 0; it < 6; it++) begin
      if (it == 0) drive(1, 1, 1, 0, 0);
      else         drive(0, 0, 1, 0, 0);
      chk_eq("R4", "start strobe", start, 1);
      chk_eq("R4", "blink in run", blink, 0);
      chk_eq("R4", "check 0", chk, 0);
      @(negedge clk);
      chk_eq("R4", "start single", start, 0);
      for (int c = 1; c < n_checks(it); c++) begin
        drive(0, 0, 1, 0, 0);
        chk_eq("R5", "check step", chk, c);
      end
      drive(0, 0, 1, 0, 0);
      chk_eq("R5", "next item", item, it + 1);
      chk_eq("R5", "selection blink", blink, 1);
      chk_eq("R5", "check cleared", chk, 0);
    end
    drive(0, 0, 1, 0, 0);
    chk_eq("R4", "exit leaves", in_test, 0);
    chk_eq("R4", "no start on exit", start, 0);
    // R6 skip confirm on item 0
    enter();
    drive(0, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0);
    chk_eq("R6", "skip blink", blink, 1);
    drive(0, 1, 0, 0, 0);
    chk_eq("R6", "left ignored blink", blink, 1);
    chk_eq("R6", "left ignored check", chk, 0);
    chk_eq("R6", "left ignored item", item, 0);
    drive(1, 0, 0, 0, 0);
    chk_eq("R6", "cancel blink", blink, 0);
    chk_eq("R6", "cancel check", chk, 0);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    chk_eq("R6", "skip advances", chk, 1);
    chk_eq("R6", "back in run", blink, 0);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    chk_eq("R6", "skip last -> item", item, 1);
    chk_eq("R6", "skip last blink", blink, 1);
    // R7 next confirm on item 1
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 0, 0);
    drive(0, 1, 0, 0, 0);
    chk_eq("R7", "next blink", blink, 1);
    drive(0, 1, 0, 0, 0);
    chk_eq("R7", "left ignored check", chk, 1);
    chk_eq("R7", "left ignored blink", blink, 1);
    drive(1, 0, 0, 0, 0);
    chk_eq("R7", "cancel blink", blink, 0);
    chk_eq("R7", "cancel check", chk, 1);
    drive(0, 1, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    chk_eq("R7", "next item", item, 2);
    chk_eq("R7", "next check", chk, 0);
    chk_eq("R7", "next blink sel", blink, 1);
    // R8 done pulse on item 2
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 1);
    chk_eq("R8", "done item", item, 3);
    chk_eq("R8", "done blink", blink, 1);
    // R9 timeout boundary
    ticks(60);
    chk_eq("R9", "60 ticks stay", in_test, 1);
    drive(1, 0, 0, 0, 0);
    chk_eq("R9", "event moves", item, 4);
    ticks(60);
    chk_eq("R9", "restart stay", in_test, 1);
    ticks(1);
    chk_eq("R9", "61st tick exits", in_test, 0);
    chk_eq("R9", "item after exit", item, 0);
    enter();
    drive(0, 0, 1, 0, 0);
    ticks(100);
    chk_eq("R9", "no timeout in run", in_test, 1);
    chk_eq("R9", "still running", blink, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule